// File: doc/BRIEF.md
# Table-Driven Quad SPI Flash Read Sequencer

This block reads from a quad-capable serial NOR flash by running a small instruction program instead of a hard-wired read state machine. A register port loads a lookup table. Each table word holds two 16-bit instructions. A read request carries a start address and a byte count. When it is accepted, the engine drops chip select, waits out a setup interval, and runs the table slots in order. A slot can send a command byte, send address bits, insert idle clocks, or capture read data. The run stops at a stop instruction or after the last slot. Chip select is held low for a hold interval and then released.

The operands tune the transfer: the number of address bits (24 or 32, for example), the dummy clock count, and for each step whether one or four data lines are used. Captured read data is packed into bytes, and each byte comes out with a one-cycle strobe. A done pulse marks the end of the transaction. Requests use a ready/valid handshake, so a request made while a transfer is running waits and is not lost.

Top module: `qspi_seq_engine`

## Requirements
- R1: An instruction is 16 bits: opcode in bits [15:10], lane selector in [9:8] (value 2 selects four lines, any other value one line), operand in [7:0]. A table word holds two instructions. Bits [15:0] form the earlier slot and bits [31:16] the later one. Words run from index 0 upward. Opcodes: 0 stop, 1 command, 2 address, 3 dummy, 4 read. Any other code ends the sequence like a stop.
- R2: A command instruction sends its operand MSB first. On one line it uses io_out[0] over 8 serial clocks with io_oe = 4'b0001. On four lines it takes 2 clocks with the high nibble first.
- R3: An address instruction sends the low N bits of the request address, MSB first, where N is the operand limited to ADDR_W. It takes N clocks on one line or ceil(N/4) clocks on four lines, with io_oe = 4'b1111.
- R4: A dummy instruction inserts operand-many serial clocks with io_oe = 0. A dummy or address instruction whose clock count is zero takes no clock at all. Read clocks also have io_oe = 0.
- R5: A read instruction captures exactly req_len bytes. On four lines it takes the high nibble first from io_in[3:0]. On one line it takes MSB first from io_in[1]. Each byte appears on rd_data with a one-cycle rd_valid pulse while chip select is still low.
- R6: A stop instruction, or running past the last slot, ends the sequence. No later slot produces a serial clock.
- R7: The serial clock is high for exactly one system cycle and low for at least one. io_out changes only when sck falls, and io_in is sampled as sck rises.
- R8: cs_n is low for at least 2*CS_SETUP system cycles before the first rising sck. It stays low for at least 2*CS_HOLD system cycles after the last falling sck. sck stays low while cs_n is high.
- R9: done pulses for exactly one cycle, in the cycle where cs_n returns high.
- R10: req_ready is high only while no transaction is running. A request held valid while the engine is busy is accepted later and carried out in order.
- R11: During and just after reset, cs_n is 1 and sck, io_oe, rd_valid and done are 0, and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_wr_en | input | 1 | Table write strobe |
| lut_wr_idx | input | $clog2(LUT_WORDS) | Table word index |
| lut_wr_data | input | 32 | Two packed instructions |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | ADDR_W | Flash start address |
| req_len | input | LEN_W | Number of bytes to read |
| rd_data | output | 8 | Captured byte |
| rd_valid | output | 1 | rd_data strobe |
| done | output | 1 | Transaction finished |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data to the flash lines |
| io_oe | output | 4 | Output enable per line |
| io_in | input | 4 | Data from the flash lines |

## Verification
The hardest cases to reach are the sequence-termination corners. One is a table that fills every slot and ends only by running off the end, with zero-length dummy slots that must produce no clock. Another is a stop placed right after the command, with a read further on that must never run. The bench loads tables with exactly these shapes. A flash model decodes the command and address from the pins and answers with address-derived data, so a wrong bit count shows up as wrong data. The stall case is reached by issuing a second request directly after the first is accepted, so its valid stays high for the whole first transfer.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

   localparam logic [5:0] OPC_STOP  = 6'd0;
   localparam logic [5:0] OPC_CMD   = 6'd1;
   localparam logic [5:0] OPC_ADDR  = 6'd2;
   localparam logic [5:0] OPC_DUMMY = 6'd3;
   localparam logic [5:0] OPC_READ  = 6'd4;

   localparam logic [1:0] LANES_QUAD = 2'd2;

   typedef struct packed {
      logic [5:0] op;
      logic [1:0] lanes;
      logic [7:0] operand;
   } instr_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOAD,
      ST_SHIFT,
      ST_HOLD
   } seq_state_e;

endpackage

// File: rtl/qspi_lut_bank.sv
module qspi_lut_bank
   import qspi_seq_pkg::*;
#(
   parameter int LUT_WORDS = 4,
   localparam int IDX_W  = $clog2(LUT_WORDS),
   localparam int SLOT_W = $clog2(2 * LUT_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [31:0]       wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output instr_t            rd_instr
);

   logic [31:0] words_q [LUT_WORDS];

   for (genvar i = 0; i < LUT_WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words_q[i] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            words_q[i] <= wr_data;
      end
   end

   logic [31:0] sel_word;
   always_comb begin
      sel_word = words_q[rd_slot[SLOT_W-1:1]];
      rd_instr = rd_slot[0] ? instr_t'(sel_word[31:16]) : instr_t'(sel_word[15:0]);
   end

endmodule

// File: rtl/qspi_instr_decode.sv
module qspi_instr_decode
   import qspi_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int CYC_W  = 20
) (
   input  instr_t            instr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic [5:0]        op,
   output logic              quad,
   output logic              is_end,
   output logic [CYC_W-1:0]  clocks,
   output logic [ADDR_W-1:0] preload
);

   logic [8:0] abits;
   logic [8:0] ashift;

   always_comb begin
      abits  = ({1'b0, instr.operand} > 9'(ADDR_W)) ? 9'(ADDR_W) : {1'b0, instr.operand};
      ashift = 9'(ADDR_W) - abits;
      op      = instr.op;
      quad    = (instr.lanes == LANES_QUAD);
      is_end  = 1'b0;
      clocks  = '0;
      preload = '0;
      case (instr.op)
         OPC_CMD: begin
            preload = ADDR_W'(instr.operand) << (ADDR_W - 8);
            clocks  = quad ? CYC_W'(2) : CYC_W'(8);
         end
         OPC_ADDR: begin
            preload = addr << ashift;
            clocks  = quad ? CYC_W'((abits + 9'd3) >> 2) : CYC_W'(abits);
         end
         OPC_DUMMY: begin
            clocks = CYC_W'(instr.operand);
         end
         OPC_READ: begin
            clocks = quad ? CYC_W'({len, 1'b0}) : CYC_W'({len, 3'b000});
         end
         default: begin
            is_end = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/qspi_rx_packer.sv
module qspi_rx_packer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample_en,
   input  logic       quad,
   input  logic [3:0] lines,
   output logic [7:0] byte_out,
   output logic       byte_valid
);

   logic [7:0] acc_q;
   logic [2:0] fill_q;
   logic [7:0] acc_nxt;
   logic [3:0] fill_nxt;

   always_comb begin
      if (quad) begin
         acc_nxt  = {acc_q[3:0], lines};
         fill_nxt = {1'b0, fill_q} + 4'd4;
      end else begin
         acc_nxt  = {acc_q[6:0], lines[1]};
         fill_nxt = {1'b0, fill_q} + 4'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         fill_q     <= '0;
         byte_out   <= '0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (clear) begin
            fill_q <= '0;
         end else if (sample_en) begin
            acc_q <= acc_nxt;
            if (fill_nxt[3]) begin
               fill_q     <= '0;
               byte_out   <= acc_nxt;
               byte_valid <= 1'b1;
            end else begin
               fill_q <= fill_nxt[2:0];
            end
         end
      end
   end

endmodule

// File: rtl/qspi_seq_engine.sv
module qspi_seq_engine
   import qspi_seq_pkg::*;
#(
   parameter int LUT_WORDS = 4,
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int CS_SETUP  = 3,
   parameter int CS_HOLD   = 3,
   localparam int IDX_W    = $clog2(LUT_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lut_wr_en,
   input  logic [IDX_W-1:0]  lut_wr_idx,
   input  logic [31:0]       lut_wr_data,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              sck,
   output logic              cs_n,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in
);

   localparam int NSLOT     = 2 * LUT_WORDS;
   localparam int SLOT_W    = $clog2(NSLOT);
   localparam int CYC_W     = (LEN_W + 4 > 10) ? LEN_W + 4 : 10;
   localparam int SETUP_CYC = 2 * CS_SETUP;
   localparam int HOLD_CYC  = 2 * CS_HOLD;

   if (LUT_WORDS < 2) begin : g_chk_words
      $error("LUT_WORDS must be at least 2");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_chk_addr
      $error("ADDR_W must lie between 8 and 64");
   end
   if (LEN_W < 1) begin : g_chk_len
      $error("LEN_W must be positive");
   end
   if (CS_SETUP < 0 || CS_SETUP > 255 || CS_HOLD < 0 || CS_HOLD > 255) begin : g_chk_cs
      $error("chip select timing out of range");
   end

   seq_state_e         state_q;
   logic               phase_q;
   logic [CYC_W-1:0]   cnt_q;
   logic [SLOT_W:0]    slot_q;
   logic [ADDR_W-1:0]  sh_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   len_q;
   logic [5:0]         cur_op_q;
   logic               cur_quad_q;
   logic               sck_q;
   logic               cs_n_q;
   logic               done_q;

   instr_t             slot_instr;
   logic [5:0]         dec_op;
   logic               dec_quad;
   logic               dec_end;
   logic [CYC_W-1:0]   dec_clocks;
   logic [ADDR_W-1:0]  dec_preload;
   logic               slots_spent;
   logic               sample_en;
   logic               pk_clear;

   qspi_lut_bank #(
      .LUT_WORDS (LUT_WORDS)
   ) u_lut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lut_wr_en),
      .wr_idx   (lut_wr_idx),
      .wr_data  (lut_wr_data),
      .rd_slot  (slot_q[SLOT_W-1:0]),
      .rd_instr (slot_instr)
   );

   qspi_instr_decode #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .CYC_W  (CYC_W)
   ) u_dec (
      .instr   (slot_instr),
      .addr    (addr_q),
      .len     (len_q),
      .op      (dec_op),
      .quad    (dec_quad),
      .is_end  (dec_end),
      .clocks  (dec_clocks),
      .preload (dec_preload)
   );

   assign slots_spent = (slot_q == (SLOT_W + 1)'(NSLOT));
   assign sample_en   = (state_q == ST_SHIFT) && !phase_q && (cur_op_q == OPC_READ);
   assign pk_clear    = (state_q == ST_LOAD);

   qspi_rx_packer u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (pk_clear),
      .sample_en  (sample_en),
      .quad       (cur_quad_q),
      .lines      (io_in),
      .byte_out   (rd_data),
      .byte_valid (rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= 1'b0;
         cnt_q      <= '0;
         slot_q     <= '0;
         sh_q       <= '0;
         addr_q     <= '0;
         len_q      <= '0;
         cur_op_q   <= OPC_STOP;
         cur_quad_q <= 1'b0;
         sck_q      <= 1'b0;
         cs_n_q     <= 1'b1;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  len_q   <= req_len;
                  slot_q  <= '0;
                  cs_n_q  <= 1'b0;
                  cnt_q   <= (SETUP_CYC == 0) ? '0 : CYC_W'(SETUP_CYC - 1);
                  state_q <= (SETUP_CYC == 0) ? ST_LOAD : ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt_q == '0)
                  state_q <= ST_LOAD;
               else
                  cnt_q <= cnt_q - 1'b1;
            end
            ST_LOAD: begin
               if (slots_spent || dec_end) begin
                  cnt_q   <= (HOLD_CYC == 0) ? '0 : CYC_W'(HOLD_CYC - 1);
                  state_q <= ST_HOLD;
               end else if (dec_clocks == '0) begin
                  slot_q <= slot_q + 1'b1;
               end else begin
                  sh_q       <= dec_preload;
                  cur_op_q   <= dec_op;
                  cur_quad_q <= dec_quad;
                  cnt_q      <= dec_clocks - 1'b1;
                  phase_q    <= 1'b0;
                  state_q    <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (!phase_q) begin
                  sck_q   <= 1'b1;
                  phase_q <= 1'b1;
               end else begin
                  sck_q   <= 1'b0;
                  phase_q <= 1'b0;
                  if (cnt_q == '0) begin
                     slot_q  <= slot_q + 1'b1;
                     state_q <= ST_LOAD;
                  end else begin
                     cnt_q <= cnt_q - 1'b1;
                     sh_q  <= cur_quad_q ? (sh_q << 4) : (sh_q << 1);
                  end
               end
            end
            ST_HOLD: begin
               if (cnt_q == '0) begin
                  cs_n_q  <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic drive_now;
   assign drive_now = (state_q == ST_SHIFT) &&
                      ((cur_op_q == OPC_CMD) || (cur_op_q == OPC_ADDR));

   always_comb begin
      io_oe  = 4'b0000;
      io_out = 4'b0000;
      if (drive_now) begin
         if (cur_quad_q) begin
            io_oe  = 4'b1111;
            io_out = sh_q[ADDR_W-1 -: 4];
         end else begin
            io_oe  = 4'b0001;
            io_out = {3'b000, sh_q[ADDR_W-1]};
         end
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign sck       = sck_q;
   assign cs_n      = cs_n_q;
   assign done      = done_q;

endmodule

// File: rtl/qspi_seq_engine_chk.sv
module qspi_seq_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sck,
   input logic [3:0] io_out,
   input logic [3:0] io_oe,
   input logic       req_ready,
   input logic       rd_valid,
   input logic       done
);

   p_sck_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sck |=> !sck);

   p_out_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(io_out));

   p_sck_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !req_ready);

   p_done_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(cs_n));

   p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_byte_in_txn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !cs_n);

   p_drive_in_txn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|io_oe) |-> !cs_n);

endmodule

bind qspi_seq_engine qspi_seq_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .sck       (sck),
   .io_out    (io_out),
   .io_oe     (io_oe),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .done      (done)
);

// File: tb/qspi_seq_engine_test.sv
module qspi_seq_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lut_wr_en = 1'b0;
   logic [1:0]  lut_wr_idx = '0;
   logic [31:0] lut_wr_data = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        done;
   logic        sck;
   logic        cs_n;
   logic [3:0]  io_out;
   logic [3:0]  io_oe;
   logic [3:0]  io_in = '0;

   always #10 clk = ~clk;

   qspi_seq_engine uut (
      .clk (clk), .rst_n (rst_n),
      .lut_wr_en (lut_wr_en), .lut_wr_idx (lut_wr_idx), .lut_wr_data (lut_wr_data),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_addr (req_addr), .req_len (req_len),
      .rd_data (rd_data), .rd_valid (rd_valid), .done (done),
      .sck (sck), .cs_n (cs_n), .io_out (io_out), .io_oe (io_oe), .io_in (io_in)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic [7:0] fmem(input [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
   endfunction

   function automatic [15:0] mk(input [5:0] op, input [1:0] lanes, input [7:0] opnd);
      return {op, lanes, opnd};
   endfunction

   // current table shape known to the flash model
   int       cfg_cmd = 0;
   int       cfg_addr_bits = 24;
   bit       cfg_addr_quad = 1;
   int       cfg_dummy = 6;
   bit       cfg_rd_quad = 1;

   int       q_cmd[$];
   longint   q_addr[$];
   int       q_rise[$];
   int       q_bytes[$];
   int       q_data[$];

   function automatic int addr_clks();
      return cfg_addr_quad ? (cfg_addr_bits + 3) / 4 : cfg_addr_bits;
   endfunction

   task automatic send(input [31:0] a, input [15:0] n);
      logic [31:0] mask;
      logic [31:0] base;
      mask = (cfg_addr_bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << cfg_addr_bits) - 1);
      base = a & mask;
      q_cmd.push_back(cfg_cmd);
      q_addr.push_back(longint'(base));
      q_rise.push_back(8 + addr_clks() + cfg_dummy + int'(n) * (cfg_rd_quad ? 2 : 8));
      q_bytes.push_back(int'(n));
      for (int k = 0; k < int'(n); k++) q_data.push_back(int'(fmem(base + 32'(k))));
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_len   = n;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_stop_after_cmd(input [31:0] a, input [15:0] n);
      q_cmd.push_back(cfg_cmd);
      q_addr.push_back(0);
      q_rise.push_back(8);
      q_bytes.push_back(0);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_len   = n;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic lut_wr(input [1:0] idx, input [31:0] d);
      @(negedge clk);
      lut_wr_en = 1'b1; lut_wr_idx = idx; lut_wr_data = d;
      @(negedge clk);
      lut_wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (q_rise.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // flash model and monitor, all at the falling system edge
   longint cyc = 0;
   logic   prev_sck = 1'b0, prev_cs = 1'b1;
   int     rises = 0, bytes_seen = 0, oe_bad = 0, stall_cycles = 0;
   logic [7:0]  cap_cmd;
   logic [31:0] cap_addr;
   longint t_cs_fall = 0, t_first_rise = 0, t_last_fall = 0, t_cs_rise = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (req_valid && !req_ready) stall_cycles++;
         if (prev_cs && !cs_n) begin
            rises = 0; bytes_seen = 0; oe_bad = 0;
            cap_cmd = '0; cap_addr = '0;
            t_cs_fall = cyc;
         end
         if (!prev_sck && sck) begin
            if (rises == 0) t_first_rise = cyc;
            if (rises < 8) begin
               cap_cmd = {cap_cmd[6:0], io_out[0]};
               if (io_oe != 4'b0001) oe_bad++;
            end else if (rises < 8 + addr_clks()) begin
               cap_addr = cfg_addr_quad ? {cap_addr[27:0], io_out} : {cap_addr[30:0], io_out[0]};
               if (io_oe != (cfg_addr_quad ? 4'b1111 : 4'b0001)) oe_bad++;
            end else begin
               if (io_oe != 4'b0000) oe_bad++;
            end
            rises++;
         end
         if (prev_sck && !sck) begin
            int pre;
            int k;
            logic [7:0] b;
            t_last_fall = cyc;
            pre = 8 + addr_clks() + cfg_dummy;
            if (rises >= pre) begin
               k = rises - pre;
               if (cfg_rd_quad) begin
                  b = fmem(cap_addr + 32'(k / 2));
                  io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
               end else begin
                  b = fmem(cap_addr + 32'(k / 8));
                  io_in = {2'b00, b[7 - (k % 8)], 1'b0};
               end
            end
         end
         if (rd_valid) begin
            bytes_seen++;
            if (q_data.size() == 0)
               chk(0, "R5", longint'(rd_data), 0);
            else begin
               int e;
               e = q_data.pop_front();
               chk(int'(rd_data) == e, "R5", longint'(rd_data), longint'(e));
            end
         end
         if (!prev_cs && cs_n) t_cs_rise = cyc;
         if (done) begin
            chk(cs_n == 1'b1, "R9", longint'(cs_n), 1);
            if (q_rise.size() == 0) chk(0, "R10", 0, 1);
            else begin
               int ec, er, eb;
               longint ea;
               ec = q_cmd.pop_front(); ea = q_addr.pop_front();
               er = q_rise.pop_front(); eb = q_bytes.pop_front();
               chk(int'(cap_cmd) == ec, "R2", longint'(cap_cmd), longint'(ec));
               chk(longint'(cap_addr) == ea, "R3", longint'(cap_addr), ea);
               chk(rises == er, "R6", longint'(rises), longint'(er));
               chk(bytes_seen == eb, "R5", longint'(bytes_seen), longint'(eb));
               chk(oe_bad == 0, "R4", longint'(oe_bad), 0);
               chk(t_first_rise - t_cs_fall >= 6, "R8", t_first_rise - t_cs_fall, 6);
               chk(t_cs_rise - t_last_fall >= 6, "R8", t_cs_rise - t_last_fall, 6);
            end
         end
      end
      prev_sck = sck;
      prev_cs  = cs_n;
   end

   // R7: serial clock high exactly one system cycle (bench side)
   int high_run = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sck) high_run++; else high_run = 0;
         if (high_run > 1) chk(0, "R7", longint'(high_run), 1);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(cs_n == 1'b1, "R11", longint'(cs_n), 1);
      chk(sck == 1'b0, "R11", longint'(sck), 0);
      chk(req_ready == 1'b1, "R11", longint'(req_ready), 1);
      chk(io_oe == 4'b0, "R11", longint'(io_oe), 0);
      chk(rd_valid == 1'b0 && done == 1'b0, "R11", longint'({rd_valid, done}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n == 1'b1 && req_ready == 1'b1, "R11", longint'({cs_n, req_ready}), 3);

      // R1 R2 R3 R4 R5: 24-bit quad read
      lut_wr(2'd0, {mk(6'd2, 2'd2, 8'h18), mk(6'd1, 2'd0, 8'hEB)});
      lut_wr(2'd1, {mk(6'd4, 2'd2, 8'h04), mk(6'd3, 2'd2, 8'h06)});
      cfg_cmd = 8'hEB; cfg_addr_bits = 24; cfg_addr_quad = 1; cfg_dummy = 6; cfg_rd_quad = 1;
      send(32'h5512_3456, 16'd4);
      wait_idle();

      // R3: 32-bit address
      lut_wr(2'd0, {mk(6'd2, 2'd2, 8'h20), mk(6'd1, 2'd0, 8'hEC)});
      cfg_cmd = 8'hEC; cfg_addr_bits = 32;
      send(32'hA1B2_C3D4, 16'd3);
      wait_idle();

      // R5: single-line everything
      lut_wr(2'd0, {mk(6'd2, 2'd0, 8'h18), mk(6'd1, 2'd0, 8'h0B)});
      lut_wr(2'd1, {mk(6'd4, 2'd0, 8'h08), mk(6'd3, 2'd0, 8'h08)});
      cfg_cmd = 8'h0B; cfg_addr_bits = 24; cfg_addr_quad = 0; cfg_dummy = 8; cfg_rd_quad = 0;
      send(32'h00AB_CDEF, 16'd2);
      wait_idle();

      // R4 R6: every slot used, zero-length dummies, end by running out of slots
      lut_wr(2'd0, {mk(6'd2, 2'd2, 8'h18), mk(6'd1, 2'd0, 8'hEB)});
      lut_wr(2'd1, {mk(6'd3, 2'd2, 8'h04), mk(6'd3, 2'd2, 8'h02)});
      lut_wr(2'd2, {mk(6'd3, 2'd2, 8'h00), mk(6'd3, 2'd2, 8'h00)});
      lut_wr(2'd3, {mk(6'd4, 2'd2, 8'h04), mk(6'd3, 2'd2, 8'h00)});
      cfg_cmd = 8'hEB; cfg_addr_bits = 24; cfg_addr_quad = 1; cfg_dummy = 6; cfg_rd_quad = 1;
      send(32'h0000_0FF0, 16'd5);
      wait_idle();

      // R6: stop right after the command; later read must not run
      lut_wr(2'd0, {mk(6'd0, 2'd0, 8'h00), mk(6'd1, 2'd0, 8'h9F)});
      cfg_cmd = 8'h9F;
      send_stop_after_cmd(32'h0000_1234, 16'd2);
      wait_idle();
      chk(q_data.size() == 0, "R6", longint'(q_data.size()), 0);

      // R10: second request stalls during the first
      lut_wr(2'd0, {mk(6'd2, 2'd2, 8'h18), mk(6'd1, 2'd0, 8'hEB)});
      lut_wr(2'd1, {mk(6'd4, 2'd2, 8'h04), mk(6'd3, 2'd2, 8'h06)});
      lut_wr(2'd2, 32'h0);
      lut_wr(2'd3, 32'h0);
      cfg_cmd = 8'hEB; cfg_addr_bits = 24; cfg_addr_quad = 1; cfg_dummy = 6; cfg_rd_quad = 1;
      stall_cycles = 0;
      send(32'h0000_0100, 16'd2);
      send(32'h0000_0200, 16'd3);
      wait_idle();
      chk(stall_cycles > 0, "R10", longint'(stall_cycles), 1);
      chk(q_data.size() == 0 && q_rise.size() == 0, "R10",
          longint'(q_data.size() + q_rise.size()), 0);
      chk(cs_n == 1'b1 && req_ready == 1'b1, "R10", longint'({cs_n, req_ready}), 3);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule